// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen architecturally visible 32-bit registers of a processor with a 26-bit address space. Some register indices have several physical copies, and the current processor mode picks which copy an index reaches. Fast-interrupt mode has private copies of indices 8 to 14. Interrupt mode and supervisor mode each have private copies of indices 13 and 14 only. All other indices are shared with user mode. Index 15 is not stored in the array: it is the program counter, and only its word-address field (bits 25:2) is kept.

Two combinational read ports and one synchronous write port serve the datapath. A read of index 15 returns the masked program counter plus an offset given with the read. When the port's status select is high, that value is also ORed with the status bits outside the address field. An exception-entry input changes the mode and writes the return address into the new mode's index-14 copy, both in one clock edge.

The mode is held by a four-state machine. The states are MODE_USER (code 00), MODE_FAST (01), MODE_IRQ (10) and MODE_SUPER (11), and reset enters MODE_SUPER. There are three kinds of transition. Exception entry moves to the mode given by the exception kind. A mode request moves to the requested code. With neither input active, the state holds.

Top module: `banked_regfile`

## Requirements
- R1: After reset `mode_out` is 2'b11 (supervisor), every stored register reads zero, and the program counter reads zero.
- R2: Mode codes are 00 user, 01 fast interrupt, 10 interrupt, 11 supervisor. A `mode_req_en` pulse loads `mode_req` on the clock edge, so reads in the same cycle still use the old mapping. Without a request or an exception, the mode holds.
- R3: Indices 0 to 7 reach the same register in every mode. Indices 8 to 12 reach one shared copy in user, interrupt and supervisor modes.
- R4: Fast-interrupt mode has its own copies of indices 8 to 14. Interrupt mode and supervisor mode each have their own copies of indices 13 and 14. A write in one mode never changes another mode's private copy.
- R5: A write to index 15 keeps only bits 25:2, with all other bits cleared. A plain read of index 15 returns (pc + offset) masked to bits 25:2, so the sum wraps within 26 bits.
- R6: A read of index 15 with the status select high returns the R5 value ORed with `status_in` bits 31:26 and 1:0.
- R7: Exception entry with `exc_kind` 2'b10 (interrupt) or 2'b01 (fast interrupt) moves to the mode of the same code and writes the masked pc+8 into that mode's index 14.
- R8: Exception entry with `exc_kind` 2'b00 or 2'b11 moves to supervisor mode and writes the masked pc+4 into the supervisor index 14.
- R9: In an exception-entry cycle, the exception decides the new mode over any `mode_req_en`. A normal write to index 14 in that cycle is dropped and changes no copy.
- R10: The two read ports use their own index, offset and status select, and can read different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_req_en | input | 1 | Load `mode_req` into the mode on this edge |
| mode_req | input | 2 | Requested mode code |
| exc_en | input | 1 | Take an exception on this edge |
| exc_kind | input | 2 | 01 fast interrupt, 10 interrupt, 00/11 other |
| status_in | input | 32 | Status bits merged on status-form reads of index 15 |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write index (15 = program counter) |
| wr_data | input | 32 | Write data |
| rda_idx | input | 4 | Port A index |
| rda_off | input | 26 | Port A offset added to the program counter |
| rda_stat | input | 1 | Port A status-merged form for index 15 |
| rda_data | output | 32 | Port A data |
| rdb_idx | input | 4 | Port B index |
| rdb_off | input | 26 | Port B offset added to the program counter |
| rdb_stat | input | 1 | Port B status-merged form for index 15 |
| rdb_data | output | 32 | Port B data |
| mode_out | output | 2 | Current mode code |

## Verification
The bench writes a different value into each banked copy. It then moves through every ordered pair of modes and reads indices 13 and 14 after each move. A design that aliased two banks would return a neighbour's value after some move. It also checks that indices 8 and 12 differ only in fast-interrupt mode. A wrong bank boundary would show through one of these indices.

The program-counter checks use an all-ones write and a read offset that carries past bit 25. A design without the mask or without the 26-bit wrap would return high bits. It also checks the status-merged form, and a supervisor entry from the top address, where pc+4 must wrap to zero.

Exception entry is issued together with a write to index 14 and a mode request. A design with the wrong priority would end in the requested mode, or would overwrite the new link value or the user copy.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

    typedef enum logic [1:0] {
        MODE_USER  = 2'b00,
        MODE_FAST  = 2'b01,
        MODE_IRQ   = 2'b10,
        MODE_SUPER = 2'b11
    } mode_e;

    localparam int IDX_W      = 4;
    localparam int PC_IDX     = 15;
    localparam int LINK_IDX   = 14;
    localparam int FAST_FIRST = 8;
    localparam int PRIV_FIRST = 13;
    localparam int N_USER     = 15;
    localparam int N_FAST     = 7;
    localparam int N_PRIV     = 2;
    localparam int FAST_BASE  = N_USER;
    localparam int IRQ_BASE   = FAST_BASE + N_FAST;
    localparam int SUPER_BASE = IRQ_BASE + N_PRIV;
    localparam int N_SLOT     = SUPER_BASE + N_PRIV;
    localparam int SLOT_W     = $clog2(N_SLOT);

    // Physical slot for a visible index under a given mode.
    function automatic logic [SLOT_W-1:0] phys_slot(mode_e m, logic [IDX_W-1:0] idx);
        logic [SLOT_W-1:0] s;
        s = SLOT_W'(idx);
        if (m == MODE_FAST && idx >= IDX_W'(FAST_FIRST) && idx <= IDX_W'(LINK_IDX))
            s = SLOT_W'(idx) - SLOT_W'(FAST_FIRST) + SLOT_W'(FAST_BASE);
        else if (m == MODE_IRQ && idx >= IDX_W'(PRIV_FIRST) && idx <= IDX_W'(LINK_IDX))
            s = SLOT_W'(idx) - SLOT_W'(PRIV_FIRST) + SLOT_W'(IRQ_BASE);
        else if (m == MODE_SUPER && idx >= IDX_W'(PRIV_FIRST) && idx <= IDX_W'(LINK_IDX))
            s = SLOT_W'(idx) - SLOT_W'(PRIV_FIRST) + SLOT_W'(SUPER_BASE);
        return s;
    endfunction

endpackage

// File: rtl/bank_map.sv
module bank_map
    import bankreg_pkg::*;
(
    input  mode_e             mode,
    input  logic [IDX_W-1:0]  idx,
    output logic [SLOT_W-1:0] slot
);
    always_comb slot = phys_slot(mode, idx);
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
    import bankreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_req_en,
    input  logic [1:0] mode_req,
    input  logic       exc_en,
    input  logic [1:0] exc_kind,
    output mode_e      mode_q,
    output mode_e      exc_mode
);
    mode_e mode_d;

    always_comb begin
        unique case (exc_kind)
            2'b01:   exc_mode = MODE_FAST;
            2'b10:   exc_mode = MODE_IRQ;
            default: exc_mode = MODE_SUPER;
        endcase
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_USER, MODE_FAST, MODE_IRQ, MODE_SUPER: begin
                if (exc_en)
                    mode_d = exc_mode;
                else if (mode_req_en)
                    mode_d = mode_e'(mode_req);
            end
            default: mode_d = MODE_SUPER;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_SUPER;
        else        mode_q <= mode_d;
    end

    // R2
    hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_en && !mode_req_en) |=> $stable(mode_q));

    // R7
    irq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_en && exc_kind == 2'b10) |=> mode_q == MODE_IRQ);

    // R8
    other_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_en && (exc_kind == 2'b00 || exc_kind == 2'b11)) |=> mode_q == MODE_SUPER);
endmodule

// File: rtl/pc_unit.sv
module pc_unit #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pc_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] status_in,
    input  logic [ADDR_W-1:0] rd_off  [2],
    input  logic              rd_stat [2],
    input  logic [1:0]        exc_kind,
    output logic [DATA_W-1:0] rd_view [2],
    output logic [DATA_W-1:0] link_val
);
    localparam logic [DATA_W-1:0] ADDR_MASK =
        {{(DATA_W-ADDR_W){1'b0}}, {(ADDR_W-2){1'b1}}, 2'b00};

    logic [DATA_W-1:0] pc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pc_q <= '0;
        else if (wr_pc_en) pc_q <= wr_data & ADDR_MASK;
    end

    for (genvar p = 0; p < 2; p++) begin : g_view
        logic [DATA_W-1:0] addr;
        always_comb begin
            addr = (pc_q + DATA_W'(rd_off[p])) & ADDR_MASK;
            rd_view[p] = rd_stat[p] ? (addr | (status_in & ~ADDR_MASK)) : addr;
        end
    end

    always_comb begin
        if (exc_kind == 2'b01 || exc_kind == 2'b10)
            link_val = (pc_q + DATA_W'(8)) & ADDR_MASK;
        else
            link_val = (pc_q + DATA_W'(4)) & ADDR_MASK;
    end

    // R5
    pc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pc_en |=> pc_q == ($past(wr_data) & ADDR_MASK));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_req_en,
    input  logic [1:0]        mode_req,
    input  logic              exc_en,
    input  logic [1:0]        exc_kind,
    input  logic [DATA_W-1:0] status_in,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [3:0]        rda_idx,
    input  logic [ADDR_W-1:0] rda_off,
    input  logic              rda_stat,
    output logic [DATA_W-1:0] rda_data,
    input  logic [3:0]        rdb_idx,
    input  logic [ADDR_W-1:0] rdb_off,
    input  logic              rdb_stat,
    output logic [DATA_W-1:0] rdb_data,
    output logic [1:0]        mode_out
);
    localparam int N_MAP = 4; // read A, read B, write, link

    mode_e             mode_q;
    mode_e             exc_mode;
    logic [DATA_W-1:0] store_q [N_SLOT];
    logic [DATA_W-1:0] pc_view [2];
    logic [ADDR_W-1:0] rd_off  [2];
    logic              rd_stat [2];
    logic [DATA_W-1:0] link_val;
    mode_e             map_mode [N_MAP];
    logic [IDX_W-1:0]  map_idx  [N_MAP];
    logic [SLOT_W-1:0] map_slot [N_MAP];
    logic              wr_pc, wr_arr;

    mode_fsm i_mode (
        .clk, .rst_n, .mode_req_en, .mode_req, .exc_en, .exc_kind,
        .mode_q, .exc_mode
    );

    assign rd_off[0]  = rda_off;
    assign rd_off[1]  = rdb_off;
    assign rd_stat[0] = rda_stat;
    assign rd_stat[1] = rdb_stat;
    assign wr_pc      = wr_en && wr_idx == IDX_W'(PC_IDX);
    assign wr_arr     = wr_en && wr_idx != IDX_W'(PC_IDX) &&
                        !(exc_en && wr_idx == IDX_W'(LINK_IDX));

    pc_unit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_pc (
        .clk, .rst_n, .wr_pc_en(wr_pc), .wr_data, .status_in,
        .rd_off, .rd_stat, .exc_kind, .rd_view(pc_view), .link_val
    );

    always_comb begin
        map_mode[0] = mode_q;   map_idx[0] = rda_idx;
        map_mode[1] = mode_q;   map_idx[1] = rdb_idx;
        map_mode[2] = mode_q;   map_idx[2] = wr_idx;
        map_mode[3] = exc_mode; map_idx[3] = IDX_W'(LINK_IDX);
    end

    for (genvar m = 0; m < N_MAP; m++) begin : g_map
        bank_map i_map (.mode(map_mode[m]), .idx(map_idx[m]), .slot(map_slot[m]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < N_SLOT; s++) store_q[s] <= '0;
        end else begin
            if (wr_arr) store_q[map_slot[2]] <= wr_data;
            if (exc_en) store_q[map_slot[3]] <= link_val;
        end
    end

    assign rda_data = (rda_idx == IDX_W'(PC_IDX)) ? pc_view[0] : store_q[map_slot[0]];
    assign rdb_data = (rdb_idx == IDX_W'(PC_IDX)) ? pc_view[1] : store_q[map_slot[1]];
    assign mode_out = mode_q;

    // R7
    link_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_en |=> store_q[$past(map_slot[3])] == $past(link_val));

    // R4
    user_r13_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !exc_en && mode_q == MODE_USER && wr_idx == 4'd13)
        |=> ($stable(store_q[SUPER_BASE]) && $stable(store_q[IRQ_BASE])));

    // R9
    link_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_en && wr_en && wr_idx == 4'd14 && mode_q == MODE_USER && exc_kind != 2'b01)
        |=> $stable(store_q[LINK_IDX]));
endmodule

// File: tb/test_banked_regfile.sv
module test_banked_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_req_en = 1'b0;
    logic [1:0]  mode_req = 2'b00;
    logic        exc_en = 1'b0;
    logic [1:0]  exc_kind = 2'b00;
    logic [31:0] status_in = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rda_idx = '0, rdb_idx = '0;
    logic [25:0] rda_off = '0, rdb_off = '0;
    logic        rda_stat = 1'b0, rdb_stat = 1'b0;
    logic [31:0] rda_data, rdb_data;
    logic [1:0]  mode_out;
    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    banked_regfile i_banked_regfile (.*);

    // {mode, index, value}
    localparam logic [37:0] VEC [14] = '{
        {2'b11, 4'd3,  32'h0003_4444},
        {2'b00, 4'd0,  32'h0A0A_0000},
        {2'b00, 4'd8,  32'h0008_1111},
        {2'b00, 4'd12, 32'h000C_1111},
        {2'b00, 4'd13, 32'h000D_1111},
        {2'b00, 4'd14, 32'h000E_1111},
        {2'b01, 4'd8,  32'h0008_2222},
        {2'b01, 4'd12, 32'h000C_2222},
        {2'b01, 4'd13, 32'h000D_2222},
        {2'b01, 4'd14, 32'h000E_2222},
        {2'b10, 4'd13, 32'h000D_3333},
        {2'b10, 4'd14, 32'h000E_3333},
        {2'b11, 4'd13, 32'h000D_4444},
        {2'b11, 4'd14, 32'h000E_4444}
    };

    function automatic logic [31:0] exp_priv(logic [1:0] m, logic [3:0] idx);
        logic [15:0] lo;
        lo = (m == 2'b00) ? 16'h1111 : (m == 2'b01) ? 16'h2222 :
             (m == 2'b10) ? 16'h3333 : 16'h4444;
        return {12'h000, idx, lo};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_mode(logic [1:0] m);
        @(negedge clk); mode_req_en = 1'b1; mode_req = m;
        @(negedge clk); mode_req_en = 1'b0;
    endtask

    task automatic write_reg(logic [3:0] idx, logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic read_a(logic [3:0] idx, logic [25:0] off, logic st, output logic [31:0] d);
        @(negedge clk); rda_idx = idx; rda_off = off; rda_stat = st;
        #1 d = rda_data;
    endtask

    task automatic take_exc(logic [1:0] kind);
        @(negedge clk); exc_en = 1'b1; exc_kind = kind;
        @(negedge clk); exc_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 mode after reset", {30'd0, mode_out}, 32'd3);
        read_a(4'd5, '0, 1'b0, d);  check("R1 r5 after reset", d, 32'd0);
        read_a(4'd15, '0, 1'b0, d); check("R1 pc after reset", d, 32'd0);

        // R2 mode loads on the edge, not before
        @(negedge clk); mode_req_en = 1'b1; mode_req = 2'b00;
        #1 check("R2 mode before edge", {30'd0, mode_out}, 32'd3);
        @(negedge clk); mode_req_en = 1'b0;
        check("R2 mode after edge", {30'd0, mode_out}, 32'd0);
        @(negedge clk);
        check("R2 mode holds", {30'd0, mode_out}, 32'd0);

        // Vector table: write, then read back in owning mode (R3, R4)
        for (int i = 0; i < 14; i++) begin
            set_mode(VEC[i][37:36]);
            write_reg(VEC[i][35:32], VEC[i][31:0]);
        end
        for (int i = 0; i < 14; i++) begin
            set_mode(VEC[i][37:36]);
            read_a(VEC[i][35:32], '0, 1'b0, d);
            check($sformatf("R4 vec %0d readback", i), d, VEC[i][31:0]);
        end

        // R3 shared indices, R10 both ports at once
        for (int m = 0; m < 4; m++) begin
            set_mode(2'(m));
            @(negedge clk);
            rda_idx = 4'd3; rdb_idx = 4'd0; rda_stat = 1'b0; rdb_stat = 1'b0;
            #1;
            check($sformatf("R3 r3 mode %0d", m), rda_data, 32'h0003_4444);
            check($sformatf("R10 portB r0 mode %0d", m), rdb_data, 32'h0A0A_0000);
            rda_idx = 4'd8; rdb_idx = 4'd12;
            #1;
            check($sformatf("R3 r8 mode %0d", m), rda_data,
                  (m == 1) ? 32'h0008_2222 : 32'h0008_1111);
            check($sformatf("R3 r12 mode %0d", m), rdb_data,
                  (m == 1) ? 32'h000C_2222 : 32'h000C_1111);
        end

        // R4 every ordered pair of modes
        for (int f = 0; f < 4; f++) begin
            for (int t = 0; t < 4; t++) begin
                if (f != t) begin
                    set_mode(2'(f));
                    set_mode(2'(t));
                    read_a(4'd13, '0, 1'b0, d);
                    check($sformatf("R4 r13 %0d->%0d", f, t), d, exp_priv(2'(t), 4'hD));
                    read_a(4'd14, '0, 1'b0, d);
                    check($sformatf("R4 r14 %0d->%0d", f, t), d, exp_priv(2'(t), 4'hE));
                end
            end
        end

        // R5 PC masking and wrap, R6 status form
        write_reg(4'd15, 32'hFFFF_FFFF);
        read_a(4'd15, '0, 1'b0, d);      check("R5 pc masked", d, 32'h03FF_FFFC);
        read_a(4'd15, 26'd4, 1'b0, d);   check("R5 pc wrap", d, 32'h0000_0000);
        status_in = 32'hF000_0003;
        read_a(4'd15, '0, 1'b1, d);      check("R6 pc with status", d, 32'hF3FF_FFFF);
        @(negedge clk); rdb_idx = 4'd15; rdb_off = 26'd8; rdb_stat = 1'b0;
        #1 check("R10 portB pc plain", rdb_data, 32'h0000_0004);

        // R7 interrupt entry
        set_mode(2'b00);
        write_reg(4'd15, 32'h0000_0100);
        take_exc(2'b10);
        check("R7 irq mode", {30'd0, mode_out}, 32'd2);
        read_a(4'd14, '0, 1'b0, d);      check("R7 irq link", d, 32'h0000_0108);
        set_mode(2'b00);
        read_a(4'd14, '0, 1'b0, d);      check("R4 user r14 kept", d, 32'h000E_1111);

        // R7 fast entry
        write_reg(4'd15, 32'h0000_0200);
        take_exc(2'b01);
        check("R7 fast mode", {30'd0, mode_out}, 32'd1);
        read_a(4'd14, '0, 1'b0, d);      check("R7 fast link", d, 32'h0000_0208);

        // R8 other exception, with wrap from the top address
        write_reg(4'd15, 32'hFFFF_FFFC);
        take_exc(2'b11);
        check("R8 super mode", {30'd0, mode_out}, 32'd3);
        read_a(4'd14, '0, 1'b0, d);      check("R8 super link wrap", d, 32'h0000_0000);
        set_mode(2'b00);
        write_reg(4'd15, 32'h0000_0400);
        take_exc(2'b00);
        check("R8 kind 00 mode", {30'd0, mode_out}, 32'd3);
        read_a(4'd14, '0, 1'b0, d);      check("R8 kind 00 link", d, 32'h0000_0404);

        // R9 exception beats write to r14 and a mode request
        set_mode(2'b00);
        @(negedge clk);
        exc_en = 1'b1; exc_kind = 2'b10;
        wr_en = 1'b1; wr_idx = 4'd14; wr_data = 32'hDEAD_BEEF;
        mode_req_en = 1'b1; mode_req = 2'b01;
        @(negedge clk);
        exc_en = 1'b0; wr_en = 1'b0; mode_req_en = 1'b0;
        check("R9 exception mode wins", {30'd0, mode_out}, 32'd2);
        read_a(4'd14, '0, 1'b0, d);      check("R9 irq link wins", d, 32'h0000_0408);
        set_mode(2'b00);
        read_a(4'd14, '0, 1'b0, d);      check("R9 user r14 untouched", d, 32'h000E_1111);
        set_mode(2'b01);
        read_a(4'd14, '0, 1'b0, d);      check("R9 fast r14 untouched", d, 32'h0000_0208);

        finish_run();
    end
endmodule